// File: doc/BRIEF.md
# NAND Flash Bus Timing Sequencer

This block converts a stream of host requests into pin-level NAND flash bus cycles. Each request carries a kind (command byte, address byte, data write or data read) and, for the first three, a data word. Requests enter a 16-entry buffer through a valid/ready handshake. They leave in arrival order as strobed cycles on chip enable, the command and address latch lines, the active-low write and read strobes, and a data bus. The data bus is brought out as separate output, output-enable and input vectors for the pad ring.

A set of static configuration inputs controls the sequencer: a bank enable, a bus width code (8 or 16 bits), a ready/busy wait enable, and two 4-bit delays. These delays set the minimum distance from the falling edge of the command latch or the address latch to the falling edge of the read strobe. A data read returns the sampled bus word as a one-cycle response pulse. The block also counts the bytes moved by data cycles. When error-correction accumulation is enabled, it pulses a strobe each time a page window of 256 to 8192 bytes fills. Bad width or page codes raise a configuration error, and the sequencer then issues no cycles.

Top module: `nand_seq_top`

## Requirements
- R1: Out of reset: buf_empty=1, req_ready=1, nand_ce_n=1, nand_we_n=1, nand_re_n=1, nand_cle=0, nand_ale=0, nand_io_oe=0, rsp_valid=0, cfg_error=0, ecc_page_stb=0.
- R2: While cfg_bank_on=0, no write or read strobe falls and nand_ce_n stays 1. Accepted requests stay buffered and run once the bank is enabled.
- R3: A bus code of 2'b10 or 2'b11, or a page code of 3'b110 or 3'b111, sets cfg_error=1. No cycle is issued while the error holds.
- R4: req_kind encodes 2'b00 command, 2'b01 address, 2'b10 data write, 2'b11 data read. A write-type cycle holds nand_we_n low for exactly one clock and then high for one clock. nand_cle=1 only for a command, nand_ale=1 only for an address, and nand_io_oe=1 with the word on nand_io_o while nand_we_n is low. Bus code 2'b01 is 16-bit and 2'b00 is 8-bit. In 8-bit mode nand_io_o[15:8]=0.
- R5: When a read is queued behind a command, nand_re_n falls max(cfg_cle_gap+1, 3) clocks after nand_cle falls.
- R6: When a read is queued behind an address, nand_re_n falls max(cfg_ale_gap+1, 3) clocks after nand_ale falls.
- R7: A read holds nand_re_n low for exactly two clocks with nand_io_oe=0. nand_io_i is sampled on the edge where nand_re_n rises, and rsp_valid pulses for one clock with that word. In 8-bit mode rsp_data[15:8]=0.
- R8: With cfg_wait_on=1, a read does not lower nand_re_n while nand_rb=0 (busy). With cfg_wait_on=0, nand_rb has no effect.
- R9: The buffer holds 16 requests. req_ready=0 while it is full, and buf_empty=1 exactly when it holds none.
- R10: With cfg_ecc_on=1, data writes and reads add 1 byte each (8-bit) or 2 bytes each (16-bit). ecc_page_stb pulses for one clock each time the total reaches 256<<cfg_page_code bytes, and the count then restarts. With cfg_ecc_on=0 the strobe never fires and the count is held at zero.
- R11: Requests are executed strictly in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bank_on | input | 1 | Bank enable |
| cfg_bus_code | input | 2 | Bus width code: 00 8-bit, 01 16-bit, others invalid |
| cfg_wait_on | input | 1 | Stall reads while device is busy |
| cfg_cle_gap | input | 4 | Command-latch-to-read-strobe delay, value+1 clocks |
| cfg_ale_gap | input | 4 | Address-latch-to-read-strobe delay, value+1 clocks |
| cfg_ecc_on | input | 1 | Enable page-window byte counting |
| cfg_page_code | input | 3 | Page window 256<<code bytes, codes 0..5 valid |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request buffer can accept |
| req_kind | input | 2 | Request kind |
| req_data | input | 16 | Command, address or write word |
| rsp_valid | output | 1 | One-clock read response pulse |
| rsp_data | output | 16 | Read response word |
| buf_empty | output | 1 | Request buffer holds nothing |
| cfg_error | output | 1 | Invalid bus or page code |
| ecc_page_stb | output | 1 | Page window complete |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_o | output | 16 | Data bus drive value |
| nand_io_oe | output | 1 | Data bus drive enable |
| nand_io_i | input | 16 | Data bus pad input |
| nand_rb | input | 1 | Device ready (1) or busy (0) |

## Verification
A corrupted sequencer state shows up on the strobe pins within one or two clocks. Examples are a write strobe held low for a second cycle, a latch line still high when the read strobe falls, or the bus driven during a read. A stale delay counter moves the read strobe edge by whole clocks, and the bench measures that edge against the latch fall with exact expected counts. Buffer pointer faults show up as a reordered, lost or repeated word at the scoreboard on the next drained cycle. A wrong byte count shows up as a strobe count off by one at page-window boundaries chosen just before and just after the limit.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int IO_W = 16;

  typedef enum logic [1:0] {
    K_CMD   = 2'b00,
    K_ADDR  = 2'b01,
    K_WDATA = 2'b10,
    K_RDATA = 2'b11
  } req_kind_e;

  typedef struct packed {
    req_kind_e         kind;
    logic [IO_W-1:0]   data;
  } req_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_WLO,
    S_WHI,
    S_RWAIT,
    S_RLO1,
    S_RLO2,
    S_RHI
  } seq_state_e;

endpackage

// File: rtl/nand_req_fifo.sv
module nand_req_fifo #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wr_ptr;
  logic [AW:0]      rd_ptr;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[AW-1:0]] <= push_data;
    if (pop)  pop_data <= mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]) && (wr_ptr[AW] != rd_ptr[AW]);
endmodule

// File: rtl/nand_cfg_check.sv
module nand_cfg_check #(
  parameter int PC_W     = 3,
  parameter int MAX_CODE = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      bus_code,
  input  logic [PC_W-1:0] page_code,
  output logic            cfg_err,
  output logic            wide
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_err <= 1'b0;
      wide    <= 1'b1;
    end else begin
      cfg_err <= bus_code[1] || (page_code > PC_W'(MAX_CODE));
      wide    <= (bus_code == 2'b01);
    end
  end
endmodule

// File: rtl/nand_cycle_fsm.sv
module nand_cycle_fsm
  import nand_seq_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             wide,
  input  logic             wait_on,
  input  logic [DLY_W-1:0] cle_dly,
  input  logic [DLY_W-1:0] ale_dly,
  input  logic             q_empty,
  input  req_kind_e        q_kind,
  input  logic [DW-1:0]    q_data,
  output logic             q_pop,
  input  logic [DW-1:0]    io_i,
  input  logic             rb,
  output logic             ce_n,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [DW-1:0]    io_o,
  output logic             io_oe,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic             xfer_done
);
  localparam int HW = DW / 2;

  seq_state_e       state;
  req_kind_e        cur_kind;
  logic [DLY_W-1:0] gap;

  assign q_pop = (state == S_IDLE) && go && !q_empty;

  function automatic logic [DW-1:0] fit(input logic w, input logic [DW-1:0] v);
    return w ? v : {{(DW-HW){1'b0}}, v[HW-1:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cur_kind  <= K_CMD;
      gap       <= '0;
      ce_n      <= 1'b1;
      cle       <= 1'b0;
      ale       <= 1'b0;
      we_n      <= 1'b1;
      re_n      <= 1'b1;
      io_o      <= '0;
      io_oe     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      xfer_done <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      xfer_done <= 1'b0;
      if (gap != '0) gap <= gap - 1'b1;
      case (state)
        S_IDLE: begin
          if (q_pop) begin
            state <= S_LOAD;
            ce_n  <= 1'b0;
          end else begin
            ce_n  <= !go;
          end
        end
        S_LOAD: begin
          cur_kind <= q_kind;
          if (q_kind == K_RDATA) begin
            state <= S_RWAIT;
          end else begin
            state <= S_WLO;
            cle   <= (q_kind == K_CMD);
            ale   <= (q_kind == K_ADDR);
            we_n  <= 1'b0;
            io_oe <= 1'b1;
            io_o  <= fit(wide, q_data);
          end
        end
        S_WLO: begin
          we_n  <= 1'b1;
          state <= S_WHI;
        end
        S_WHI: begin
          cle   <= 1'b0;
          ale   <= 1'b0;
          io_oe <= 1'b0;
          if (cle)      gap <= cle_dly;
          else if (ale) gap <= ale_dly;
          xfer_done <= (cur_kind == K_WDATA);
          state <= S_IDLE;
        end
        S_RWAIT: begin
          if ((gap == '0) && (!wait_on || rb)) begin
            re_n  <= 1'b0;
            state <= S_RLO1;
          end
        end
        S_RLO1: state <= S_RLO2;
        S_RLO2: begin
          re_n      <= 1'b1;
          rsp_valid <= 1'b1;
          rsp_data  <= fit(wide, io_i);
          xfer_done <= 1'b1;
          state     <= S_RHI;
        end
        S_RHI:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_ecc_window.sv
module nand_ecc_window #(
  parameter int PC_W     = 3,
  parameter int BASE     = 256,
  parameter int MAX_CODE = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ecc_on,
  input  logic            wide,
  input  logic [PC_W-1:0] page_code,
  input  logic            xfer,
  output logic            stb
);
  localparam int CNT_W = $clog2(BASE << MAX_CODE) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] limit;
  logic [PC_W-1:0]  code_c;

  always_comb begin
    code_c = (page_code > PC_W'(MAX_CODE)) ? PC_W'(MAX_CODE) : page_code;
    limit  = CNT_W'(BASE) << code_c;
    nxt    = cnt + (wide ? CNT_W'(2) : CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || !ecc_on) begin
      cnt <= '0;
      stb <= 1'b0;
    end else begin
      stb <= 1'b0;
      if (xfer) begin
        if (nxt >= limit) begin
          cnt <= '0;
          stb <= 1'b1;
        end else begin
          cnt <= nxt;
        end
      end
    end
  end
endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
  import nand_seq_pkg::*;
#(
  parameter int BUF_DEPTH  = 16,
  parameter int DLY_W      = 4,
  parameter int PC_W       = 3,
  parameter int PAGE_BASE  = 256,
  parameter int MAX_CODE   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_bank_on,
  input  logic [1:0]       cfg_bus_code,
  input  logic             cfg_wait_on,
  input  logic [DLY_W-1:0] cfg_cle_gap,
  input  logic [DLY_W-1:0] cfg_ale_gap,
  input  logic             cfg_ecc_on,
  input  logic [PC_W-1:0]  cfg_page_code,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [IO_W-1:0]  req_data,
  output logic             rsp_valid,
  output logic [IO_W-1:0]  rsp_data,
  output logic             buf_empty,
  output logic             cfg_error,
  output logic             ecc_page_stb,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [IO_W-1:0]  nand_io_o,
  output logic             nand_io_oe,
  input  logic [IO_W-1:0]  nand_io_i,
  input  logic             nand_rb
);
  localparam int REQ_W = $bits(req_t);

  req_t in_req;
  req_t head;
  logic q_full;
  logic q_pop;
  logic wide;
  logic xfer_done;
  logic go;

  assign in_req.kind = req_kind_e'(req_kind);
  assign in_req.data = req_data;
  assign req_ready   = !q_full;
  assign go          = cfg_bank_on && !cfg_error;

  nand_req_fifo #(.WIDTH(REQ_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .push      (req_valid && !q_full),
    .push_data (in_req),
    .pop       (q_pop),
    .pop_data  (head),
    .empty     (buf_empty),
    .full      (q_full)
  );

  nand_cfg_check #(.PC_W(PC_W), .MAX_CODE(MAX_CODE)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .bus_code  (cfg_bus_code),
    .page_code (cfg_page_code),
    .cfg_err   (cfg_error),
    .wide      (wide)
  );

  nand_cycle_fsm #(.DW(IO_W), .DLY_W(DLY_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .wide      (wide),
    .wait_on   (cfg_wait_on),
    .cle_dly   (cfg_cle_gap),
    .ale_dly   (cfg_ale_gap),
    .q_empty   (buf_empty),
    .q_kind    (head.kind),
    .q_data    (head.data),
    .q_pop     (q_pop),
    .io_i      (nand_io_i),
    .rb        (nand_rb),
    .ce_n      (nand_ce_n),
    .cle       (nand_cle),
    .ale       (nand_ale),
    .we_n      (nand_we_n),
    .re_n      (nand_re_n),
    .io_o      (nand_io_o),
    .io_oe     (nand_io_oe),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .xfer_done (xfer_done)
  );

  nand_ecc_window #(.PC_W(PC_W), .BASE(PAGE_BASE), .MAX_CODE(MAX_CODE)) u_ecc (
    .clk       (clk),
    .rst       (rst),
    .ecc_on    (cfg_ecc_on),
    .wide      (wide),
    .page_code (cfg_page_code),
    .xfer      (xfer_done),
    .stb       (ecc_page_stb)
  );
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic clk,
  input logic rst,
  input logic cfg_ecc_on,
  input logic req_ready,
  input logic buf_empty,
  input logic rsp_valid,
  input logic ecc_page_stb,
  input logic nand_ce_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_io_oe
);
  p_ce_gate_r2: assert property (@(posedge clk) disable iff (rst)
    nand_ce_n |-> (nand_we_n && nand_re_n));

  p_we_single_r4: assert property (@(posedge clk) disable iff (rst)
    !nand_we_n |=> nand_we_n);

  p_latch_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));

  p_drive_on_write_r4: assert property (@(posedge clk) disable iff (rst)
    !nand_we_n |-> nand_io_oe);

  p_re_hold_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(nand_re_n) |=> !nand_re_n);

  p_re_release_r7: assert property (@(posedge clk) disable iff (rst)
    (!nand_re_n && $past(!nand_re_n)) |=> nand_re_n);

  p_bus_free_on_read_r7: assert property (@(posedge clk) disable iff (rst)
    !nand_re_n |-> !nand_io_oe);

  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_empty_ready_r9: assert property (@(posedge clk) disable iff (rst)
    buf_empty |-> req_ready);

  p_stb_needs_ecc_r10: assert property (@(posedge clk) disable iff (rst)
    ecc_page_stb |-> $past(cfg_ecc_on));

  p_stb_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    ecc_page_stb |=> !ecc_page_stb);
endmodule

bind nand_seq_top nand_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_ecc_on   (cfg_ecc_on),
  .req_ready    (req_ready),
  .buf_empty    (buf_empty),
  .rsp_valid    (rsp_valid),
  .ecc_page_stb (ecc_page_stb),
  .nand_ce_n    (nand_ce_n),
  .nand_cle     (nand_cle),
  .nand_ale     (nand_ale),
  .nand_we_n    (nand_we_n),
  .nand_re_n    (nand_re_n),
  .nand_io_oe   (nand_io_oe)
);

// File: tb/nand_seq_top_test.sv
`timescale 1ns/1ps
module nand_seq_top_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        cfg_bank_on = 1'b0;
  logic [1:0]  cfg_bus_code = 2'b01;
  logic        cfg_wait_on = 1'b0;
  logic [3:0]  cfg_cle_gap = 4'd0;
  logic [3:0]  cfg_ale_gap = 4'd0;
  logic        cfg_ecc_on = 1'b0;
  logic [2:0]  cfg_page_code = 3'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'b00;
  logic [15:0] req_data = 16'h0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        buf_empty, cfg_error, ecc_page_stb;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [15:0] nand_io_o;
  logic [15:0] dev_data = 16'h0;
  logic        nand_rb = 1'b1;

  nand_seq_top uut (
    .clk(clk), .rst(rst), .cfg_bank_on(cfg_bank_on), .cfg_bus_code(cfg_bus_code),
    .cfg_wait_on(cfg_wait_on), .cfg_cle_gap(cfg_cle_gap), .cfg_ale_gap(cfg_ale_gap),
    .cfg_ecc_on(cfg_ecc_on), .cfg_page_code(cfg_page_code), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .buf_empty(buf_empty),
    .cfg_error(cfg_error), .ecc_page_stb(ecc_page_stb), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_io_o(nand_io_o), .nand_io_oe(nand_io_oe),
    .nand_io_i(dev_data), .nand_rb(nand_rb)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard queues
  logic [17:0] wq[$];
  logic [15:0] rq[$];

  // monitor state
  logic prev_cle = 1'b0, prev_ale = 1'b0, prev_re = 1'b1, prev_we = 1'b1, we_was_low = 1'b0;
  int   since_fall = 0, last_gap = -1, we_falls = 0, re_falls = 0, stb_cnt = 0;
  int   re_len = 0, last_re_len = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if ((prev_cle && !nand_cle) || (prev_ale && !nand_ale)) since_fall = 0;
      else since_fall++;
      if (prev_re && !nand_re_n) begin
        last_gap = since_fall;
        re_falls++;
      end
      if (prev_we && !nand_we_n) we_falls++;
      if (!nand_re_n) re_len++;
      else if (!prev_re) begin
        last_re_len = re_len;
        re_len = 0;
      end
      if (we_was_low)
        chk(nand_we_n == 1'b1, "R4 write strobe high after one low clock", 32'(nand_we_n), 32'd1);
      we_was_low = !nand_we_n;
      if (!nand_we_n) begin
        if (wq.size() == 0) begin
          chk(1'b0, "R11 unexpected write cycle", 32'(nand_io_o), 32'd0);
        end else begin
          logic [17:0] e;
          e = wq.pop_front();
          chk({nand_cle, nand_ale, nand_io_o} == e, "R4/R11 write cycle latch+data",
              32'({nand_cle, nand_ale, nand_io_o}), 32'(e));
          chk(nand_io_oe == 1'b1, "R4 bus driven during write", 32'(nand_io_oe), 32'd1);
        end
      end
      if (rsp_valid) begin
        if (rq.size() == 0) begin
          chk(1'b0, "R7 unexpected response", 32'(rsp_data), 32'd0);
        end else begin
          logic [15:0] r;
          r = rq.pop_front();
          chk(rsp_data == r, "R7 read response data", 32'(rsp_data), 32'(r));
        end
      end
      if (ecc_page_stb) stb_cnt++;
      prev_cle = nand_cle;
      prev_ale = nand_ale;
      prev_re  = nand_re_n;
      prev_we  = nand_we_n;
    end
  end

  task automatic push(input logic [1:0] k, input logic [15:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_kind  = k;
    req_data  = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [15:0] fitw(input logic [15:0] v);
    return (cfg_bus_code == 2'b01) ? v : {8'h00, v[7:0]};
  endfunction

  task automatic wr(input logic [1:0] k, input logic [15:0] d);
    wq.push_back({k == 2'b00, k == 2'b01, fitw(d)});
    push(k, d);
  endtask

  task automatic rd(input logic [15:0] v);
    dev_data = v;
    rq.push_back(fitw(v));
    push(2'b11, 16'h0);
  endtask

  task automatic drain;
    @(negedge clk);
    while (wq.size() != 0 || rq.size() != 0 || !buf_empty) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic gap_case(input bit use_ale, input int d);
    int exp;
    if (use_ale) begin
      cfg_ale_gap = 4'(d);
      wr(2'b01, 16'h0033);
    end else begin
      cfg_cle_gap = 4'(d);
      wr(2'b00, 16'h0005);
    end
    rd(16'h5A00 + 16'(d));
    drain();
    exp = (d + 1 < 3) ? 3 : d + 1;
    if (use_ale) chk(last_gap == exp, "R6 ALE fall to RE fall clocks", 32'(last_gap), 32'(exp));
    else         chk(last_gap == exp, "R5 CLE fall to RE fall clocks", 32'(last_gap), 32'(exp));
    chk(last_re_len == 2, "R7 read strobe low length", 32'(last_re_len), 32'd2);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int wf;
    int sc;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(buf_empty == 1'b1, "R1 buf_empty", 32'(buf_empty), 32'd1);
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
    chk({nand_ce_n, nand_we_n, nand_re_n} == 3'b111, "R1 strobes idle",
        32'({nand_ce_n, nand_we_n, nand_re_n}), 32'h7);
    chk({nand_cle, nand_ale, nand_io_oe, rsp_valid, cfg_error, ecc_page_stb} == 6'b0,
        "R1 controls low", 32'({nand_cle, nand_ale, nand_io_oe, rsp_valid, cfg_error, ecc_page_stb}), 32'd0);

    // R2 bank disabled keeps request buffered
    wr(2'b00, 16'h0070);
    repeat (30) @(negedge clk);
    chk(we_falls == 0, "R2 no write strobe while bank off", 32'(we_falls), 32'd0);
    chk(nand_ce_n == 1'b1, "R2 chip enable high while bank off", 32'(nand_ce_n), 32'd1);
    chk(buf_empty == 1'b0, "R9 buffer not empty with pending request", 32'(buf_empty), 32'd0);

    // R3 bad bus code blocks cycles
    cfg_bus_code = 2'b10;
    repeat (3) @(negedge clk);
    cfg_bank_on = 1'b1;
    repeat (30) @(negedge clk);
    chk(cfg_error == 1'b1, "R3 bus code 10 flags error", 32'(cfg_error), 32'd1);
    chk(we_falls == 0, "R3 no cycle under bus code error", 32'(we_falls), 32'd0);
    cfg_bus_code = 2'b01;
    drain();
    chk(we_falls == 1, "R2 buffered command runs once enabled", 32'(we_falls), 32'd1);
    chk(cfg_error == 1'b0, "R3 error clears", 32'(cfg_error), 32'd0);

    // R3 bad page code blocks cycles
    cfg_page_code = 3'd6;
    repeat (3) @(negedge clk);
    wr(2'b00, 16'h0090);
    repeat (30) @(negedge clk);
    chk(cfg_error == 1'b1, "R3 page code 6 flags error", 32'(cfg_error), 32'd1);
    chk(we_falls == 1, "R3 no cycle under page code error", 32'(we_falls), 32'd1);
    cfg_page_code = 3'd0;
    drain();
    chk(we_falls == 2, "R3 cycle resumes after page code fix", 32'(we_falls), 32'd2);

    // R4 write kinds, 16-bit then 8-bit
    wr(2'b00, 16'h0080);
    wr(2'b01, 16'h0012);
    wr(2'b10, 16'hBEEF);
    drain();
    cfg_bus_code = 2'b00;
    repeat (3) @(negedge clk);
    wr(2'b10, 16'hA5C3);
    drain();
    cfg_bus_code = 2'b01;
    repeat (3) @(negedge clk);

    // R5 / R6 latch-to-read delays
    gap_case(1'b0, 0);
    gap_case(1'b0, 2);
    gap_case(1'b0, 7);
    gap_case(1'b0, 15);
    gap_case(1'b1, 0);
    gap_case(1'b1, 5);
    gap_case(1'b1, 12);

    // R7 read in 8-bit mode
    cfg_bus_code = 2'b00;
    repeat (3) @(negedge clk);
    rd(16'hABCD);
    drain();
    chk(rq.size() == 0, "R7 8-bit read returned", 32'(rq.size()), 32'd0);
    cfg_bus_code = 2'b01;
    repeat (3) @(negedge clk);

    // R8 wait on busy
    cfg_wait_on = 1'b1;
    nand_rb = 1'b0;
    wf = re_falls;
    rd(16'h1357);
    repeat (40) @(negedge clk);
    chk(re_falls == wf, "R8 read stalled while busy", 32'(re_falls), 32'(wf));
    chk(rq.size() == 1, "R8 no response while busy", 32'(rq.size()), 32'd1);
    nand_rb = 1'b1;
    drain();
    chk(re_falls == wf + 1, "R8 read proceeds when ready", 32'(re_falls), 32'(wf + 1));
    cfg_wait_on = 1'b0;
    nand_rb = 1'b0;
    rd(16'h2468);
    drain();
    chk(rq.size() == 0, "R8 busy ignored when wait disabled", 32'(rq.size()), 32'd0);
    nand_rb = 1'b1;

    // R9 buffer full with bank off, then R11 order on drain
    cfg_bank_on = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 16; i++) wr(2'b00, 16'h00C0 + 16'(i));
    chk(req_ready == 1'b0, "R9 ready low when 16 held", 32'(req_ready), 32'd0);
    chk(buf_empty == 1'b0, "R9 not empty when full", 32'(buf_empty), 32'd0);
    cfg_bank_on = 1'b1;
    drain();
    chk(buf_empty == 1'b1, "R9 empty after drain", 32'(buf_empty), 32'd1);
    chk(req_ready == 1'b1, "R9 ready after drain", 32'(req_ready), 32'd1);

    // R10 page window, 8-bit 256 bytes
    cfg_bus_code = 2'b00;
    cfg_ecc_on = 1'b1;
    repeat (3) @(negedge clk);
    sc = stb_cnt;
    for (int i = 0; i < 255; i++) wr(2'b10, 16'hFF00 | 16'(i));
    drain();
    chk(stb_cnt == sc, "R10 no strobe at 255 bytes", 32'(stb_cnt), 32'(sc));
    wr(2'b10, 16'h0011);
    drain();
    chk(stb_cnt == sc + 1, "R10 strobe at 256 bytes", 32'(stb_cnt), 32'(sc + 1));
    // 16-bit: 127 words then one more
    cfg_bus_code = 2'b01;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 127; i++) wr(2'b10, 16'(i));
    drain();
    chk(stb_cnt == sc + 1, "R10 no strobe at 254 bytes wide", 32'(stb_cnt), 32'(sc + 1));
    rd(16'h7777);
    drain();
    chk(stb_cnt == sc + 2, "R10 read word completes page", 32'(stb_cnt), 32'(sc + 2));
    // ECC off: no strobe
    cfg_ecc_on = 1'b0;
    cfg_bus_code = 2'b00;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 260; i++) wr(2'b10, 16'(i));
    drain();
    chk(stb_cnt == sc + 2, "R10 no strobe with ECC off", 32'(stb_cnt), 32'(sc + 2));

    chk(wq.size() == 0 && rq.size() == 0, "R11 all expected cycles seen",
        32'(wq.size() + rq.size()), 32'd0);
    summary();
    $finish;
  end
endmodule